// File: doc/BRIEF.md
# Three-Wire Serial Configuration Loader

This block takes in synthesizer configuration over a three-wire serial link made of a data line, a serial clock and a load-enable strobe. All three wires are asynchronous to the system clock. They are re-timed through a flip-flop synchroniser, and their edges are found in the system clock domain. Each rising edge of the serial clock moves one data bit into a 23-bit frame register. The frame is sent most-significant bit first, so the two routing bits at the bottom of the frame are the last to arrive.

A rising edge of load-enable copies the frame into one of four holding registers. Each of the two synthesizer channels has a reference word, which holds the reference divide ratio, the pump current select and the monitor-select pair. Each channel also has a counter word, which holds the lock-select bit, the prescaler select, the phase polarity, and the swallow and main counts. The routing bits in the frame pick the destination. The block decodes the held fields and drives them straight to its outputs. A sticky flag records any load that arrived before a whole frame had been shifted in.

Top module: `cfg3w_loader`

## Requirements
- R1: After reset, both channels report a reference ratio of 3, a main count of 3 and a swallow count of 0, with every select bit and the short-frame flag at 0.
- R2: Each rising edge of the serial clock shifts the data bit into frame bit 0 and moves every older bit up one place. The first of 23 bits sent therefore ends in bit 22.
- R3: On a rising edge of load-enable, frame bit 0 selects the channel (0 for channel 0, 1 for channel 1). Frame bit 1 selects the word (0 for the reference word, 1 for the counter word).
- R4: A reference word takes its monitor-select pair from bits 2 (output bit 0) and 3 (output bit 1). It takes the ratio from bits 17..4, with the LSB at bit 4, and the pump-current-high bit from bit 18. Bits 22..19 have no effect.
- R5: A counter word takes lock-select from bit 2, prescaler select from bit 3 and phase polarity from bit 4. It takes the swallow count from bits 11..5 and the main count from bits 22..12, each with its LSB at the lower bit.
- R6: A load changes only the addressed word. The other three words keep their values, and nothing changes between loads.
- R7: Serial clock edges that arrive while load-enable is high do not shift the frame register.
- R8: A load that comes after fewer than 23 shifted bits, counted since the previous load or since reset, still copies the current frame register. It also sets the short-frame flag, which stays set until reset. A load after 23 or more bits leaves the flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock, asynchronous |
| ser_dat | input | 1 | Serial data, asynchronous |
| ser_le | input | 1 | Load-enable strobe, asynchronous |
| ref_ratio | output | 2x14 | Reference divide ratio per channel |
| pump_hi | output | 2 | High charge-pump current select per channel |
| mon_sel | output | 2x2 | Monitor-select pair per channel |
| lock_sel | output | 2 | Lock-detect / monitor output select per channel |
| pre_sel | output | 2 | Prescaler modulus select per channel |
| pol_inv | output | 2 | Phase comparator polarity per channel |
| swallow | output | 2x7 | Swallow count per channel |
| main_div | output | 2x11 | Main counter ratio per channel |
| short_frame | output | 1 | Sticky flag for a load after an incomplete frame |

## Verification
The bench aims at the routing table with four frames of clearly different content. A design that mixed up the two routing bits would write the wrong word, and the check that the other three words stay unchanged would catch it. A reference frame with its unused top bits set exposes a decoder that leaks those bits into the ratio or the current select. A frame of 26 bits and a frame of 5 bits probe the short-frame counter. A counter that wrapped instead of saturating, or a flag that failed to stick, would show up there. Finally, serial clock pulses sent while load-enable is high would corrupt the frame register if the shifter ignored the strobe. A second load with no new bits then exposes that corruption.

// File: rtl/cfg3w_pkg.sv
package cfg3w_pkg;
   localparam int unsigned CH_COUNT   = 2;
   localparam int unsigned CTRL_BITS  = 2;
   localparam int unsigned SEL_LO     = 2;

   typedef enum logic {
      WORD_REF = 1'b0,
      WORD_CNT = 1'b1
   } word_kind_e;
endpackage

// File: rtl/cfg3w_sync.sv
module cfg3w_sync #(
   parameter int unsigned W      = 1,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   initial begin
      assert (STAGES >= 2) else $error("cfg3w_sync: STAGES below 2");
   end

   logic [W-1:0] pipe [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(STAGES); i++) pipe[i] <= '0;
      end else begin
         pipe[0] <= d;
         for (int i = 1; i < int'(STAGES); i++) pipe[i] <= pipe[i-1];
      end
   end

   assign q = pipe[STAGES-1];
endmodule

// File: rtl/cfg3w_shifter.sv
module cfg3w_shifter #(
   parameter int unsigned FRAME_W = 23
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               shift_en,
   input  logic               din,
   input  logic               load,
   output logic [FRAME_W-1:0] frame,
   output logic               short_flag
);
   localparam int unsigned CW = $clog2(FRAME_W + 1);

   logic [CW-1:0] bit_cnt;
   logic          full;

   assign full = (bit_cnt == CW'(FRAME_W));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frame <= '0;
      end else if (shift_en) begin
         frame <= {frame[FRAME_W-2:0], din};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt    <= '0;
         short_flag <= 1'b0;
      end else if (load) begin
         bit_cnt    <= '0;
         short_flag <= short_flag | ~full;
      end else if (shift_en && !full) begin
         bit_cnt <= bit_cnt + CW'(1);
      end
   end

   p_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
      shift_en |=> (frame[0] == $past(din)) &&
                   (frame[FRAME_W-1:1] == $past(frame[FRAME_W-2:0])));

   p_cnt_sat_r8: assert property (@(posedge clk) disable iff (!rst_n)
      bit_cnt <= CW'(FRAME_W));

   p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      short_flag |=> short_flag);

   p_full_noflag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (load && full && !short_flag) |=> !short_flag);
endmodule

// File: rtl/cfg3w_latch_bank.sv
module cfg3w_latch_bank
   import cfg3w_pkg::*;
#(
   parameter int unsigned FRAME_W = 23,
   parameter int unsigned REF_W   = 14,
   parameter int unsigned SWAL_W  = 7,
   parameter int unsigned MAIN_W  = 11
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              load,
   input  logic [FRAME_W-1:0]                frame,
   output logic [CH_COUNT-1:0][REF_W-1:0]    ref_ratio,
   output logic [CH_COUNT-1:0]               pump_hi,
   output logic [CH_COUNT-1:0][1:0]          mon_sel,
   output logic [CH_COUNT-1:0]               lock_sel,
   output logic [CH_COUNT-1:0]               pre_sel,
   output logic [CH_COUNT-1:0]               pol_inv,
   output logic [CH_COUNT-1:0][SWAL_W-1:0]   swallow,
   output logic [CH_COUNT-1:0][MAIN_W-1:0]   main_div
);
   localparam int unsigned RATIO_LO = SEL_LO + 2;
   localparam int unsigned PUMP_POS = RATIO_LO + REF_W;
   localparam int unsigned LOCK_POS = SEL_LO;
   localparam int unsigned PRE_POS  = SEL_LO + 1;
   localparam int unsigned POL_POS  = SEL_LO + 2;
   localparam int unsigned SWAL_LO  = SEL_LO + 3;
   localparam int unsigned MAIN_LO  = SWAL_LO + SWAL_W;

   initial begin
      assert (PUMP_POS < FRAME_W) else $error("cfg3w_latch_bank: reference word overflows frame");
      assert (MAIN_LO + MAIN_W <= FRAME_W) else $error("cfg3w_latch_bank: counter word overflows frame");
   end

   word_kind_e kind;
   assign kind = word_kind_e'(frame[1]);

   for (genvar ch = 0; ch < int'(CH_COUNT); ch++) begin : g_ch
      logic              hit;
      logic [REF_W-1:0]  ratio_q;
      logic              pump_q;
      logic [1:0]        mon_q;
      logic              lock_q;
      logic              pre_q;
      logic              pol_q;
      logic [SWAL_W-1:0] swal_q;
      logic [MAIN_W-1:0] main_q;

      assign hit = load && (frame[0] == 1'(ch));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ratio_q <= REF_W'(3);
            pump_q  <= 1'b0;
            mon_q   <= 2'b00;
         end else if (hit && kind == WORD_REF) begin
            ratio_q <= frame[RATIO_LO +: REF_W];
            pump_q  <= frame[PUMP_POS];
            mon_q   <= frame[SEL_LO +: 2];
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lock_q <= 1'b0;
            pre_q  <= 1'b0;
            pol_q  <= 1'b0;
            swal_q <= '0;
            main_q <= MAIN_W'(3);
         end else if (hit && kind == WORD_CNT) begin
            lock_q <= frame[LOCK_POS];
            pre_q  <= frame[PRE_POS];
            pol_q  <= frame[POL_POS];
            swal_q <= frame[SWAL_LO +: SWAL_W];
            main_q <= frame[MAIN_LO +: MAIN_W];
         end
      end

      assign ref_ratio[ch] = ratio_q;
      assign pump_hi[ch]   = pump_q;
      assign mon_sel[ch]   = mon_q;
      assign lock_sel[ch]  = lock_q;
      assign pre_sel[ch]   = pre_q;
      assign pol_inv[ch]   = pol_q;
      assign swallow[ch]   = swal_q;
      assign main_div[ch]  = main_q;

      p_refload_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (load && frame[1:0] == {1'b0, 1'(ch)}) |=>
            (ref_ratio[ch] == $past(frame[RATIO_LO +: REF_W])) &&
            (pump_hi[ch] == $past(frame[PUMP_POS])));

      p_cntload_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (load && frame[1:0] == {1'b1, 1'(ch)}) |=>
            (main_div[ch] == $past(frame[MAIN_LO +: MAIN_W])) &&
            (swallow[ch] == $past(frame[SWAL_LO +: SWAL_W])));

      p_other_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (!load || frame[0] != 1'(ch)) |=>
            $stable(ref_ratio[ch]) && $stable(main_div[ch]) &&
            $stable(swallow[ch]) && $stable(mon_sel[ch]));

      p_route_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (load && frame[1:0] == {1'b1, 1'(ch)}) |=>
            $stable(ref_ratio[ch]) && $stable(pump_hi[ch]));
   end
endmodule

// File: rtl/cfg3w_loader.sv
module cfg3w_loader
   import cfg3w_pkg::*;
#(
   parameter int unsigned FRAME_W     = 23,
   parameter int unsigned REF_W       = 14,
   parameter int unsigned SWAL_W      = 7,
   parameter int unsigned MAIN_W      = 11,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            ser_clk,
   input  logic                            ser_dat,
   input  logic                            ser_le,
   output logic [CH_COUNT-1:0][REF_W-1:0]  ref_ratio,
   output logic [CH_COUNT-1:0]             pump_hi,
   output logic [CH_COUNT-1:0][1:0]        mon_sel,
   output logic [CH_COUNT-1:0]             lock_sel,
   output logic [CH_COUNT-1:0]             pre_sel,
   output logic [CH_COUNT-1:0]             pol_inv,
   output logic [CH_COUNT-1:0][SWAL_W-1:0] swallow,
   output logic [CH_COUNT-1:0][MAIN_W-1:0] main_div,
   output logic                            short_frame
);
   initial begin
      assert (FRAME_W > CTRL_BITS + 1) else $error("cfg3w_loader: frame too narrow");
   end

   logic [2:0]         sync_q;
   logic               dat_s, clk_s, le_s;
   logic               clk_d, le_d;
   logic               sclk_rise, load, shift_en;
   logic [FRAME_W-1:0] frame_w;

   cfg3w_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({ser_le, ser_clk, ser_dat}),
      .q     (sync_q)
   );

   assign {le_s, clk_s, dat_s} = sync_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clk_d <= 1'b0;
         le_d  <= 1'b0;
      end else begin
         clk_d <= clk_s;
         le_d  <= le_s;
      end
   end

   assign sclk_rise = clk_s & ~clk_d;
   assign load      = le_s & ~le_d;
   assign shift_en  = sclk_rise & ~le_s;

   cfg3w_shifter #(.FRAME_W(FRAME_W)) u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .shift_en   (shift_en),
      .din        (dat_s),
      .load       (load),
      .frame      (frame_w),
      .short_flag (short_frame)
   );

   cfg3w_latch_bank #(
      .FRAME_W (FRAME_W),
      .REF_W   (REF_W),
      .SWAL_W  (SWAL_W),
      .MAIN_W  (MAIN_W)
   ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .frame     (frame_w),
      .ref_ratio (ref_ratio),
      .pump_hi   (pump_hi),
      .mon_sel   (mon_sel),
      .lock_sel  (lock_sel),
      .pre_sel   (pre_sel),
      .pol_inv   (pol_inv),
      .swallow   (swallow),
      .main_div  (main_div)
   );

   p_le_blocks_shift_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (le_s && sclk_rise) |=> $stable(frame_w));

   p_load_keeps_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> $stable(frame_w));
endmodule

// File: tb/cfg3w_loader_tb.sv
module cfg3w_loader_tb;
   localparam int CLK_PERIOD = 10;
   localparam int HALF       = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ser_clk = 1'b0, ser_dat = 1'b0, ser_le = 1'b0;

   logic [1:0][13:0] ref_ratio;
   logic [1:0]       pump_hi;
   logic [1:0][1:0]  mon_sel;
   logic [1:0]       lock_sel, pre_sel, pol_inv;
   logic [1:0][6:0]  swallow;
   logic [1:0][10:0] main_div;
   logic             short_frame;

   int checks = 0;
   int errors = 0;

   logic [22:0] m_sreg = '0;
   int          m_cnt = 0;
   logic [13:0] m_ref [2];
   logic        m_pump [2];
   logic [1:0]  m_mon [2];
   logic        m_lock [2], m_pre [2], m_pol [2];
   logic [6:0]  m_swal [2];
   logic [10:0] m_main [2];
   logic        m_short = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cfg3w_loader u_dut (
      .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_le(ser_le),
      .ref_ratio(ref_ratio), .pump_hi(pump_hi), .mon_sel(mon_sel), .lock_sel(lock_sel),
      .pre_sel(pre_sel), .pol_inv(pol_inv), .swallow(swallow), .main_div(main_div),
      .short_frame(short_frame)
   );

   task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   task automatic check_all(input string rq);
      for (int c = 0; c < 2; c++) begin
         chk({rq, " ref_ratio"}, 32'(ref_ratio[c]), 32'(m_ref[c]));
         chk({rq, " pump_hi"},   32'(pump_hi[c]),   32'(m_pump[c]));
         chk({rq, " mon_sel"},   32'(mon_sel[c]),   32'(m_mon[c]));
         chk({rq, " lock_sel"},  32'(lock_sel[c]),  32'(m_lock[c]));
         chk({rq, " pre_sel"},   32'(pre_sel[c]),   32'(m_pre[c]));
         chk({rq, " pol_inv"},   32'(pol_inv[c]),   32'(m_pol[c]));
         chk({rq, " swallow"},   32'(swallow[c]),   32'(m_swal[c]));
         chk({rq, " main_div"},  32'(main_div[c]),  32'(m_main[c]));
      end
      chk({rq, " short_frame R8"}, 32'(short_frame), 32'(m_short));
   endtask

   task automatic send_bits(input logic [31:0] val, input int n);
      for (int i = n - 1; i >= 0; i--) begin
         ser_dat = val[i];
         repeat (HALF) @(negedge clk);
         ser_clk = 1'b1;
         repeat (HALF) @(negedge clk);
         ser_clk = 1'b0;
         m_sreg = {m_sreg[21:0], val[i]};
         if (m_cnt < 23) m_cnt++;
      end
   endtask

   task automatic model_load();
      int c;
      c = int'(m_sreg[0]);
      if (m_cnt < 23) m_short = 1'b1;
      m_cnt = 0;
      if (!m_sreg[1]) begin
         m_ref[c]  = m_sreg[17:4];
         m_pump[c] = m_sreg[18];
         m_mon[c]  = m_sreg[3:2];
      end else begin
         m_lock[c] = m_sreg[2];
         m_pre[c]  = m_sreg[3];
         m_pol[c]  = m_sreg[4];
         m_swal[c] = m_sreg[11:5];
         m_main[c] = m_sreg[22:12];
      end
   endtask

   task automatic pulse_le(input int extra_clks);
      repeat (HALF) @(negedge clk);
      ser_le = 1'b1;
      repeat (HALF) @(negedge clk);
      for (int k = 0; k < extra_clks; k++) begin
         ser_dat = ~ser_dat;
         ser_clk = 1'b1;
         repeat (HALF) @(negedge clk);
         ser_clk = 1'b0;
         repeat (HALF) @(negedge clk);
      end
      ser_le = 1'b0;
      repeat (2 * HALF) @(negedge clk);
      model_load();
   endtask

   function automatic logic [22:0] mk_ref(input logic ch, input logic [1:0] mon,
                                          input logic [13:0] r, input logic pump,
                                          input logic [3:0] junk);
      return {junk, pump, r, mon[1], mon[0], 1'b0, ch};
   endfunction

   function automatic logic [22:0] mk_cnt(input logic ch, input logic lk, input logic pre,
                                          input logic pol, input logic [6:0] a,
                                          input logic [10:0] n);
      return {n, a, pol, pre, lk, 1'b1, ch};
   endfunction

   task automatic t_reset();
      check_all("R1 reset");
   endtask

   task automatic t_routing();
      send_bits(32'(mk_ref(1'b0, 2'b01, 14'd1000, 1'b1, 4'h0)), 23); pulse_le(0);
      check_all("R3 R4 R6 ch0 reference");
      send_bits(32'(mk_ref(1'b1, 2'b10, 14'd16383, 1'b0, 4'hF)), 23); pulse_le(0);
      check_all("R3 R4 R6 ch1 reference, unused bits set");
      send_bits(32'(mk_cnt(1'b0, 1'b1, 1'b0, 1'b1, 7'd127, 11'd2047)), 23); pulse_le(0);
      check_all("R3 R5 R6 ch0 counter");
      send_bits(32'(mk_cnt(1'b1, 1'b0, 1'b1, 1'b0, 7'd42, 11'd517)), 23); pulse_le(0);
      check_all("R2 R3 R5 R6 ch1 counter");
   endtask

   task automatic t_long_frame();
      send_bits({6'h15, 3'b101, mk_ref(1'b0, 2'b11, 14'h2AAA, 1'b0, 4'h5)}, 26);
      pulse_le(0);
      check_all("R2 R8 long frame no flag");
   endtask

   task automatic t_short_frame();
      send_bits(32'h0000001F, 5);
      pulse_le(0);
      check_all("R8 short frame latches and flags");
   endtask

   task automatic t_le_high_clocks();
      send_bits(32'(mk_ref(1'b0, 2'b10, 14'd777, 1'b1, 4'h0)), 23);
      pulse_le(3);
      check_all("R7 load with clocks during strobe");
      pulse_le(0);
      check_all("R7 reload shows frame register untouched");
   endtask

   initial begin
      for (int c = 0; c < 2; c++) begin
         m_ref[c] = 14'd3; m_pump[c] = 1'b0; m_mon[c] = 2'b00;
         m_lock[c] = 1'b0; m_pre[c] = 1'b0; m_pol[c] = 1'b0;
         m_swal[c] = 7'd0; m_main[c] = 11'd3;
      end
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_routing();
      t_long_frame();
      t_short_frame();
      t_le_high_clocks();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule